// File: doc/BRIEF.md
# Segment Address Translation Unit

This unit turns a segment selector and an offset into an address, or into a fault code when the access is not allowed. It has two modes, chosen per request. In real mode no table is involved: the selector is shifted left by four bit positions and added to the low 16 bits of the offset, giving a 20-bit address. In protected mode the selector indexes a small table of segment descriptors kept in internal registers. Each descriptor holds a base, a limit, a present flag and three permission flags.

A protected-mode request is checked in a fixed order. The selector must fall inside the table and the access code must be defined. The descriptor must be present. The offset must not exceed the limit. The access type must be allowed by the permission flags. Only a request that passes every check produces the sum of base and offset, wrapped to 32 bits. The descriptor table is filled through a plain write port, one entry per cycle. Each request gives its result one clock later.

Top module: `seg_xlate`

## Requirements
- R1: After reset `rsp_valid_o`, `addr_o` and `fault_o` are 0 and every descriptor entry reads as not present.
- R2: `rsp_valid_o` is high in the cycle after a cycle with `req_valid_i` high, and low otherwise. `addr_o` and `fault_o` keep their values in any cycle that follows one without a request.
- R3: In real mode (`mode_i`=0) the result is `addr_o` = (`sel_i`*16 + `offset_i[15:0]`) mod 2^20, with the upper address bits zero and fault code 0. Offset bits above bit 15 and the table contents have no effect.
- R4: In protected mode (`mode_i`=1), a selector value of `NUM_DESC` or above, or the reserved access code 3, gives fault code 1 (general).
- R5: In protected mode, an entry whose present flag is clear gives fault code 2 (not present).
- R6: In protected mode, an offset greater than the entry's limit gives fault code 3 (limit). An offset equal to the limit is inside the segment.
- R7: Permission bit 0 allows read (access code 0), bit 1 allows write (access code 1) and bit 2 allows fetch (access code 2). An access whose bit is clear gives fault code 4 (permission).
- R8: When several checks fail, the fault reported is the first in this order: general, not present, limit, permission.
- R9: A protected-mode request that passes all checks gives `addr_o` = (base + `offset_i`) mod 2^32 with fault code 0. Any fault drives `addr_o` to 0.
- R10: A write with `tbl_we_i` high replaces entry `tbl_idx_i` at the clock edge. A request in the same cycle still sees the old entry. A write to an index of `NUM_DESC` or above changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tbl_we_i | input | 1 | Descriptor write strobe |
| tbl_idx_i | input | SEL_W | Entry index to write |
| tbl_base_i | input | ADDR_W | Base of the written entry |
| tbl_limit_i | input | OFF_W | Highest valid offset of the written entry |
| tbl_present_i | input | 1 | Present flag of the written entry |
| tbl_perm_i | input | 3 | Permission flags: bit 0 read, bit 1 write, bit 2 fetch |
| req_valid_i | input | 1 | Translation request strobe |
| mode_i | input | 1 | 0 real mode, 1 protected mode |
| sel_i | input | SEL_W | Segment selector |
| offset_i | input | OFF_W | Offset within the segment |
| acc_i | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 reserved |
| rsp_valid_o | output | 1 | Result valid, one cycle after the request |
| addr_o | output | ADDR_W | Translated address, 0 on fault |
| fault_o | output | 3 | 0 none, 1 general, 2 not present, 3 limit, 4 permission |

## Verification
A corrupted descriptor register does not show up right away. It appears only on the next protected-mode request to that entry, one cycle after the request, as a wrong address or a wrong fault code. A broken real-mode adder or a wrong check order shows up on the first request that reaches it, also one cycle later. The sweeps therefore touch every entry with offsets at zero, at the limit, one past the limit and across the top of the address space, and with every access code. After each table write they read the entries back through translation requests.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_GEN    = 3'd1,
    FLT_ABSENT = 3'd2,
    FLT_BOUND  = 3'd3,
    FLT_PERM   = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  localparam int PERM_W  = 3;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_xlate_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int SEL_W    = 16,
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  widx_i,
  input  logic [ADDR_W-1:0] wbase_i,
  input  logic [OFF_W-1:0]  wlimit_i,
  input  logic              wpresent_i,
  input  logic [PERM_W-1:0] wperm_i,
  input  logic [SEL_W-1:0]  ridx_i,
  output logic              rhit_o,
  output logic [ADDR_W-1:0] rbase_o,
  output logic [OFF_W-1:0]  rlimit_o,
  output logic              rpresent_o,
  output logic [PERM_W-1:0] rperm_o
);
  logic [ADDR_W-1:0] base_q    [NUM_DESC];
  logic [OFF_W-1:0]  limit_q   [NUM_DESC];
  logic              present_q [NUM_DESC];
  logic [PERM_W-1:0] perm_q    [NUM_DESC];

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]    <= '0;
        limit_q[g]   <= '0;
        present_q[g] <= 1'b0;
        perm_q[g]    <= '0;
      end else if (we_i && (widx_i == SEL_W'(g))) begin
        base_q[g]    <= wbase_i;
        limit_q[g]   <= wlimit_i;
        present_q[g] <= wpresent_i;
        perm_q[g]    <= wperm_i;
      end
    end
  end

  assign rhit_o = ({1'b0, ridx_i} < (SEL_W+1)'(NUM_DESC));

  always_comb begin
    rbase_o    = '0;
    rlimit_o   = '0;
    rpresent_o = 1'b0;
    rperm_o    = '0;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (ridx_i == SEL_W'(i)) begin
        rbase_o    = base_q[i];
        rlimit_o   = limit_q[i];
        rpresent_o = present_q[i];
        rperm_o    = perm_q[i];
      end
    end
  end
endmodule

// File: rtl/seg_real_path.sv
module seg_real_path #(
  parameter int SEL_W    = 16,
  parameter int SHIFT    = 4,
  parameter int RM_OFF_W = 16,
  parameter int ADDR_W   = 32
) (
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [RM_OFF_W-1:0] offset_i,
  output logic [ADDR_W-1:0]   addr_o
);
  localparam int REAL_W = SEL_W + SHIFT;

  logic [REAL_W-1:0] seg_base;
  logic [REAL_W-1:0] seg_off;
  logic [REAL_W-1:0] seg_sum;

  assign seg_base = {sel_i, {SHIFT{1'b0}}};
  assign seg_off  = REAL_W'(offset_i);
  assign seg_sum  = seg_base + seg_off; // wraps at 2^REAL_W
  assign addr_o   = ADDR_W'(seg_sum);
endmodule

// File: rtl/seg_prot_check.sv
module seg_prot_check
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 32
) (
  input  logic              hit_i,
  input  logic [1:0]        acc_i,
  input  logic              present_i,
  input  logic [OFF_W-1:0]  limit_i,
  input  logic [PERM_W-1:0] perm_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [2:0]        fault_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic perm_ok;

  always_comb begin
    unique case (acc_i)
      ACC_READ:  perm_ok = perm_i[PERM_RD];
      ACC_WRITE: perm_ok = perm_i[PERM_WR];
      ACC_FETCH: perm_ok = perm_i[PERM_EX];
      default:   perm_ok = 1'b0;
    endcase
  end

  // fixed priority: general, absent, bound, permission
  always_comb begin
    if (!hit_i || (acc_i == ACC_RSVD)) fault_o = FLT_GEN;
    else if (!present_i)               fault_o = FLT_ABSENT;
    else if (offset_i > limit_i)       fault_o = FLT_BOUND;
    else if (!perm_ok)                 fault_o = FLT_PERM;
    else                               fault_o = FLT_NONE;
  end

  assign addr_o = (fault_o == FLT_NONE) ? ADDR_W'(base_i + ADDR_W'(offset_i)) : '0;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int SEL_W    = 16,
  parameter int OFF_W    = 32,
  parameter int ADDR_W   = 32,
  parameter int SHIFT    = 4,
  parameter int RM_OFF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_we_i,
  input  logic [SEL_W-1:0]  tbl_idx_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [OFF_W-1:0]  tbl_limit_i,
  input  logic              tbl_present_i,
  input  logic [2:0]        tbl_perm_i,
  input  logic              req_valid_i,
  input  logic              mode_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [1:0]        acc_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2:0]        fault_o
);
  logic              d_hit;
  logic [ADDR_W-1:0] d_base;
  logic [OFF_W-1:0]  d_limit;
  logic              d_present;
  logic [PERM_W-1:0] d_perm;
  logic [ADDR_W-1:0] real_addr;
  logic [ADDR_W-1:0] prot_addr;
  logic [2:0]        prot_fault;
  logic [ADDR_W-1:0] nxt_addr;
  logic [2:0]        nxt_fault;

  seg_desc_table #(
    .NUM_DESC(NUM_DESC), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (tbl_we_i),
    .widx_i     (tbl_idx_i),
    .wbase_i    (tbl_base_i),
    .wlimit_i   (tbl_limit_i),
    .wpresent_i (tbl_present_i),
    .wperm_i    (tbl_perm_i),
    .ridx_i     (sel_i),
    .rhit_o     (d_hit),
    .rbase_o    (d_base),
    .rlimit_o   (d_limit),
    .rpresent_o (d_present),
    .rperm_o    (d_perm)
  );

  seg_real_path #(
    .SEL_W(SEL_W), .SHIFT(SHIFT), .RM_OFF_W(RM_OFF_W), .ADDR_W(ADDR_W)
  ) u_real (
    .sel_i    (sel_i),
    .offset_i (offset_i[RM_OFF_W-1:0]),
    .addr_o   (real_addr)
  );

  seg_prot_check #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W)
  ) u_prot (
    .hit_i     (d_hit),
    .acc_i     (acc_i),
    .present_i (d_present),
    .limit_i   (d_limit),
    .perm_i    (d_perm),
    .base_i    (d_base),
    .offset_i  (offset_i),
    .fault_o   (prot_fault),
    .addr_o    (prot_addr)
  );

  assign nxt_addr  = mode_i ? prot_addr : real_addr;
  assign nxt_fault = mode_i ? prot_fault : 3'(FLT_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      addr_o      <= '0;
      fault_o     <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        addr_o  <= nxt_addr;
        fault_o <= nxt_fault;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_xlate_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int SEL_W    = 16,
  parameter int ADDR_W   = 32,
  parameter int SHIFT    = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              mode_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [2:0]        fault_o
);
  localparam int REAL_W = SEL_W + SHIFT;

  p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && $stable(addr_o) && $stable(fault_o)));

  p_real_clean_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !mode_i) |=> (fault_o == FLT_NONE && (addr_o >> REAL_W) == '0));

  p_bad_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i && ({1'b0, sel_i} >= (SEL_W+1)'(NUM_DESC))) |=> fault_o == FLT_GEN);

  p_fault_addr_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && fault_o != FLT_NONE) |-> addr_o == '0);

  p_fault_code_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o <= FLT_PERM);
endmodule

bind seg_xlate seg_xlate_chk #(
  .NUM_DESC(NUM_DESC), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .SHIFT(SHIFT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .mode_i      (mode_i),
  .sel_i       (sel_i),
  .rsp_valid_o (rsp_valid_o),
  .addr_o      (addr_o),
  .fault_o     (fault_o)
);

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [15:0] tbl_idx = '0;
  logic [31:0] tbl_base = '0;
  logic [31:0] tbl_limit = '0;
  logic        tbl_present = 1'b0;
  logic [2:0]  tbl_perm = '0;
  logic        req_valid = 1'b0;
  logic        mode = 1'b0;
  logic [15:0] sel = '0;
  logic [31:0] offset = '0;
  logic [1:0]  acc = '0;
  logic        rsp_valid;
  logic [31:0] addr;
  logic [2:0]  fault;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_base [ND];
  logic [31:0] m_lim  [ND];
  logic        m_pres [ND];
  logic [2:0]  m_perm [ND];

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate #(.NUM_DESC(ND)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx), .tbl_base_i(tbl_base),
    .tbl_limit_i(tbl_limit), .tbl_present_i(tbl_present), .tbl_perm_i(tbl_perm),
    .req_valid_i(req_valid), .mode_i(mode), .sel_i(sel), .offset_i(offset), .acc_i(acc),
    .rsp_valid_o(rsp_valid), .addr_o(addr), .fault_o(fault)
  );

  task automatic check(string req, logic [35:0] got, logic [35:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // expected {fault, addr} for a protected request
  function automatic logic [34:0] model(logic [15:0] s, logic [31:0] o, logic [1:0] a);
    logic ok;
    if (s >= 16'(ND) || a == 2'd3) return {3'd1, 32'h0};
    if (!m_pres[s[2:0]]) return {3'd2, 32'h0};
    if (o > m_lim[s[2:0]]) return {3'd3, 32'h0};
    ok = m_perm[s[2:0]][a];
    if (!ok) return {3'd4, 32'h0};
    return {3'd0, m_base[s[2:0]] + o};
  endfunction

  function automatic string tag_of(logic [2:0] f);
    case (f)
      3'd0: return "R9";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic write_desc(logic [15:0] i, logic [31:0] b, logic [31:0] l, logic p, logic [2:0] pm);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = i; tbl_base = b; tbl_limit = l; tbl_present = p; tbl_perm = pm;
    @(negedge clk);
    tbl_we = 1'b0;
    if (i < 16'(ND)) begin
      m_base[i[2:0]] = b; m_lim[i[2:0]] = l; m_pres[i[2:0]] = p; m_perm[i[2:0]] = pm;
    end
  endtask

  task automatic xlate(logic m, logic [15:0] s, logic [31:0] o, logic [1:0] a);
    @(negedge clk);
    req_valid = 1'b1; mode = m; sel = s; offset = o; acc = a;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ND; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_pres[i] = 1'b0; m_perm[i] = '0;
    end
    #(CLK_PERIOD*2 + 1);
    // R1 reset state
    check("R1", {rsp_valid, addr, fault}, 36'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1: every entry absent after reset
    for (int i = 0; i < ND; i++) begin
      xlate(1'b1, 16'(i), 32'h0, 2'd0);
      check("R1", {1'b0, fault, addr}, {4'd2, 32'h0});
    end

    // R3: real-mode sweep, upper offset bits set to prove they are ignored
    for (int k = 0; k < 64; k++) begin
      for (int j = 0; j < 5; j++) begin
        logic [15:0] s;
        logic [15:0] lo;
        logic [19:0] e;
        s = 16'(k * 1031);
        if (k == 63) s = 16'hFFFF;
        case (j)
          0: lo = 16'h0000;
          1: lo = 16'hFFFF;
          2: lo = 16'h8000;
          3: lo = 16'(k * 37 + 5);
          default: lo = 16'h000F;
        endcase
        e = {s, 4'h0} + {4'h0, lo};
        xlate(1'b0, s, {16'hABCD ^ 16'(k), lo}, 2'(j));
        check("R3", {1'b0, fault, addr}, {4'd0, 12'h0, e});
        check("R2", {35'h0, rsp_valid}, 36'h1);
      end
    end

    // load table
    for (int i = 0; i < ND; i++) begin
      logic [31:0] b;
      logic [31:0] l;
      b = (i == 7) ? 32'hFFFF_FF00 : (32'h1000_0000 * i + 32'h0123_4560 + i);
      l = (i == 7) ? 32'hFFFF_FFFF : ((32'h100 << i) - 1);
      write_desc(16'(i), b, l, (i != 5), 3'(i));
    end

    // R4-R9 protected sweep
    for (int s = 0; s < ND + 2; s++) begin
      for (int a = 0; a < 4; a++) begin
        for (int j = 0; j < 5; j++) begin
          logic [31:0] o;
          logic [34:0] e;
          logic [31:0] lim;
          lim = (s < ND) ? m_lim[s] : 32'h100;
          case (j)
            0: o = 32'h0;
            1: o = lim;
            2: o = lim + 1;
            3: o = 32'h80;
            default: o = 32'h200;
          endcase
          e = model(16'(s), o, 2'(a));
          xlate(1'b1, 16'(s), o, 2'(a));
          check(tag_of(e[34:32]), {1'b0, fault, addr}, {1'b0, e});
        end
      end
    end

    // R2: outputs hold in an idle cycle
    xlate(1'b1, 16'd7, 32'h200, 2'd0);
    check("R9", {1'b0, fault, addr}, {4'd0, 32'h0000_0100});
    @(posedge clk); #1;
    check("R2", {rsp_valid, fault, addr}, {1'b0, 3'd0, 32'h0000_0100});

    // R8: absent beats limit and permission (entry 5 absent, perm 101)
    xlate(1'b1, 16'd5, 32'hFFFF_0000, 2'd1);
    check("R8", {1'b0, fault, addr}, {4'd2, 32'h0});
    // R8: limit beats permission (entry 0 perm 000)
    xlate(1'b1, 16'd0, 32'h1000, 2'd1);
    check("R8", {1'b0, fault, addr}, {4'd3, 32'h0});
    // R8: out-of-range selector beats everything
    xlate(1'b1, 16'd200, 32'hFFFF_FFFF, 2'd1);
    check("R8", {1'b0, fault, addr}, {4'd1, 32'h0});

    // R10: same-cycle write and request sees old entry
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 16'd6; tbl_base = 32'h5555_0000; tbl_limit = 32'hFFFF;
    tbl_present = 1'b1; tbl_perm = 3'b111;
    req_valid = 1'b1; mode = 1'b1; sel = 16'd6; offset = 32'h10; acc = 2'd0;
    @(posedge clk); #1;
    tbl_we = 1'b0; req_valid = 1'b0;
    check("R10", {1'b0, fault, addr}, {1'b0, model(16'd6, 32'h10, 2'd0)});
    m_base[6] = 32'h5555_0000; m_lim[6] = 32'hFFFF; m_pres[6] = 1'b1; m_perm[6] = 3'b111;
    xlate(1'b1, 16'd6, 32'h10, 2'd0);
    check("R10", {1'b0, fault, addr}, {4'd0, 32'h5555_0010});

    // R10: write to index ND changes nothing
    write_desc(16'(ND), 32'h7777_0000, 32'hFFFF_FFFF, 1'b1, 3'b111);
    xlate(1'b1, 16'(ND), 32'h0, 2'd0);
    check("R10", {1'b0, fault, addr}, {4'd1, 32'h0});
    for (int i = 0; i < ND; i++) begin
      xlate(1'b1, 16'(i), 32'h0, 2'(i % 3));
      check("R10", {1'b0, fault, addr}, {1'b0, model(16'(i), 32'h0, 2'(i % 3))});
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule